// File: doc/BRIEF.md
# Serial Audio Sample FIFO Hub

This block buffers 16-bit audio samples between a processor or DMA engine and a serial audio shifter. It holds one transmit queue, filled through register writes and drained by the shifter, and one receive queue, filled by the shifter and drained through register reads. A six-bit threshold per direction sets that queue's almost-empty and almost-full levels. The same threshold, gated by a per-direction DMA enable, raises a transfer request.

The register side is a single-cycle port with separate write and read strobes and a 3-bit word address. Read data is combinational while the read strobe is high. A read of the receive data word removes the head sample. A status word reports both fill counts and four level flags per queue. An event word combines those live flags with latched error bits. Latched errors record a take from an empty queue and a put into a full queue, along with a word-transfer event. Each event has its own enable bit, and a global enable bit gates the single interrupt line. The shifter side uses a one-cycle pop strobe for transmit and a one-cycle push strobe for receive.

Top module: `snd_fifo_hub`

## Requirements
- R1: After reset, control and interrupt enables are zero and both queues are disabled and empty. `irq`, both DMA requests, `tx_valid` and `port_en` are low. The FIFO status word (address 5) reads 0x300C.
- R2: Register addresses: 0 control, 1 transmit data (write), 2 receive data (read), 3 interrupt enable, 4 event status, 5 FIFO status, 6 clear (write). Other reads return 0. Control bits: [18:13] transmit threshold, [12:7] receive threshold, [6] transmit DMA enable, [5] receive DMA enable, [2] transmit queue enable, [1] receive queue enable, [0] port enable. Control bits 4 and 3 read back 0. Interrupt enable bits: [14] global, [12:0] per event. Bit 13 reads back 0.
- R3: Samples written to address 1 leave in write order on `tx_sample`. `tx_valid` is high whenever the enabled transmit queue is non-empty. A `tx_pop` strobe removes the head sample. The queue holds DEPTH (32) samples.
- R4: Samples pushed with `rx_push` are returned in arrival order by reads of address 2. The read word carries the sample in [15:0] and a valid flag in bit 16. An empty or disabled queue reads 0.
- R5: FIFO status: [19:14] transmit count, [13] empty, [12] almost-empty, [11] full, [10] almost-full. [9:4] receive count, [3] empty, [2] almost-empty, [1] full, [0] almost-full.
- R6: Almost-empty holds when count <= threshold. Almost-full holds when count + threshold >= DEPTH.
- R7: A push into a full queue is dropped and latches that direction's overflow bit. Transmit overflow is event bit 6 and receive overflow is event bit 0.
- R8: A pop from an empty enabled queue changes nothing else and latches that direction's starve bit. Transmit starve is event bit 7 and receive starve is event bit 1.
- R9: Writing 1 to bit 12, 7, 6, 1 or 0 of the clear register drops that latched bit. An event arriving in the same cycle keeps the bit set. Bit 12 latches on every accepted transmit pop or receive push.
- R10: Event status: [12] word transfer, [11:8] transmit empty, almost-empty, full, almost-full, [7:6] transmit starve and overflow, [5:2] receive level flags in the same order, [1:0] receive starve and overflow. Bit 13 is set when any enabled event is set. `irq` equals bit 13 ANDed with the global enable.
- R11: `dma_tx_req` is high when the transmit DMA and queue enables are set, the queue is not full and it is almost-empty. `dma_rx_req` is high when the receive DMA and queue enables are set, the queue is not empty and it is almost-full.
- R12: A disabled queue reports a count of 0, ignores pushes and pops without raising events, and is empty when it is enabled again.
- R13: A control write that clears bit 0 turns `port_en` off only if that same write clears both queue enables. A write with bit 0 set turns it on.
- R14: When a queue is empty, a push and a pop in the same cycle accept the push and flag a starve. When it is full, the pop is accepted and the push is dropped with an overflow. Otherwise both are accepted and the count is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops receive queue at address 2) |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid while reg_rd is high |
| tx_pop | input | 1 | Shifter takes the transmit head sample |
| tx_valid | output | 1 | Transmit queue enabled and non-empty |
| tx_sample | output | SW | Transmit head sample |
| rx_push | input | 1 | Shifter delivers a received sample |
| rx_sample | input | SW | Received sample |
| dma_tx_req | output | 1 | Transmit refill request |
| dma_rx_req | output | 1 | Receive drain request |
| port_en | output | 1 | Port master enable |
| irq | output | 1 | Combined interrupt |

## Verification
The register port and the shifter can touch the same queue in one cycle. A data write can meet a `tx_pop`, and a receive-data read can meet an `rx_push`. A clear write can also land in the cycle that raises the error it clears. The bench provokes these collisions on an empty queue, on a full queue and in random traffic, where the two sides are strobed independently. It judges each one against a queue model that evaluates the pop and the push against the pre-cycle fill and lets a new event win over a clear.

// File: rtl/sfh_pkg.sv
package sfh_pkg;
   localparam int THR_W = 6;
   localparam int CNT_FIELD_W = 6;
   localparam int EV_W = 13;

   typedef enum logic [2:0] {
      RA_CTRL = 3'd0,
      RA_TXD  = 3'd1,
      RA_RXD  = 3'd2,
      RA_IEN  = 3'd3,
      RA_IST  = 3'd4,
      RA_FST  = 3'd5,
      RA_CLR  = 3'd6
   } reg_addr_e;

   localparam int CT_TXTHR_LSB = 13;
   localparam int CT_RXTHR_LSB = 7;
   localparam int CT_TXDMA     = 6;
   localparam int CT_RXDMA     = 5;
   localparam int CT_TXFEN     = 2;
   localparam int CT_RXFEN     = 1;
   localparam int CT_PEN       = 0;
   localparam logic [18:0] CT_MASK = 19'h7FFE7;
   localparam logic [14:0] IE_MASK = 15'h5FFF;
   localparam int IE_GLOBAL    = 14;

   localparam int EV_WXFER = 12;
   localparam int EV_TSTV  = 7;
   localparam int EV_TOVF  = 6;
   localparam int EV_RSTV  = 1;
   localparam int EV_ROVF  = 0;

   typedef struct packed {
      logic empty;
      logic aempty;
      logic full;
      logic afull;
   } lvl_t;
endpackage

// File: rtl/sfh_fifo.sv
module sfh_fifo #(
   parameter int DW    = 16,
   parameter int DEPTH = 32,
   localparam int AW   = $clog2(DEPTH),
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          flush,
   input  logic          push,
   input  logic [DW-1:0] wdat,
   input  logic          pop,
   output logic [DW-1:0] head,
   output logic [CW-1:0] cnt,
   output logic          push_ok,
   output logic          pop_ok,
   output logic          ovf_ev,
   output logic          stv_ev
);
   logic [DW-1:0] mem [DEPTH];
   logic [AW-1:0] wp_q, rp_q;
   logic [CW-1:0] cnt_q;
   logic          full, empty;

   assign full    = (cnt_q == CW'(DEPTH));
   assign empty   = (cnt_q == '0);
   assign push_ok = push & ~full;
   assign pop_ok  = pop & ~empty;
   assign ovf_ev  = push & full;
   assign stv_ev  = pop & empty;
   assign head    = mem[rp_q];
   assign cnt     = cnt_q;

   always_ff @(posedge clk) begin
      if (push_ok) mem[wp_q] <= wdat;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
         wp_q  <= '0;
         rp_q  <= '0;
         cnt_q <= '0;
      end else begin
         if (push_ok) wp_q <= wp_q + 1'b1;
         if (pop_ok)  rp_q <= rp_q + 1'b1;
         unique case ({push_ok, pop_ok})
            2'b10:   cnt_q <= cnt_q + 1'b1;
            2'b01:   cnt_q <= cnt_q - 1'b1;
            default: cnt_q <= cnt_q;
         endcase
      end
   end
endmodule

// File: rtl/sfh_level.sv
module sfh_level
   import sfh_pkg::*;
#(
   parameter int DEPTH = 32,
   parameter int CW    = 6,
   parameter int TW    = 6,
   localparam int XW   = ((CW > TW) ? CW : TW) + 1
) (
   input  logic [CW-1:0] cnt,
   input  logic [TW-1:0] thr,
   input  logic          en,
   output lvl_t          lvl,
   output logic [CW-1:0] cnt_vis
);
   logic [XW-1:0] cnt_x, thr_x;

   assign cnt_vis = en ? cnt : '0;
   assign cnt_x   = XW'(cnt_vis);
   assign thr_x   = XW'(thr);

   always_comb begin
      lvl.empty  = (cnt_vis == '0);
      lvl.full   = (cnt_vis == CW'(DEPTH));
      lvl.aempty = (cnt_x <= thr_x);
      lvl.afull  = ((cnt_x + thr_x) >= XW'(DEPTH));
   end
endmodule

// File: rtl/snd_fifo_hub.sv
module snd_fifo_hub
   import sfh_pkg::*;
#(
   parameter int SW    = 16,
   parameter int DEPTH = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          reg_wr,
   input  logic          reg_rd,
   input  logic [2:0]    reg_addr,
   input  logic [31:0]   reg_wdata,
   output logic [31:0]   reg_rdata,
   input  logic          tx_pop,
   output logic          tx_valid,
   output logic [SW-1:0] tx_sample,
   input  logic          rx_push,
   input  logic [SW-1:0] rx_sample,
   output logic          dma_tx_req,
   output logic          dma_rx_req,
   output logic          port_en,
   output logic          irq
);
   localparam int CW = $clog2(DEPTH + 1);
   localparam int ND = 2;

   if (DEPTH < 2 || DEPTH > 32 || (DEPTH & (DEPTH - 1)) != 0) begin : g_chk_depth
      $error("snd_fifo_hub: DEPTH must be a power of two from 2 to 32");
   end
   if (SW < 1 || SW > 16) begin : g_chk_sw
      $error("snd_fifo_hub: SW must be 1 to 16");
   end

   logic [18:0] ctrl_q, ctrl_nxt;
   logic [14:0] ie_q;
   logic        ws_q, ts_q, to_q, rs_q, ro_q;

   logic [ND-1:0] fen, push_req, pop_req, push_ok, pop_ok, ovf_ev, stv_ev;
   logic [SW-1:0] pdat    [ND];
   logic [SW-1:0] head    [ND];
   logic [CW-1:0] cnt_raw [ND];
   logic [CW-1:0] cnt_vis [ND];
   logic [THR_W-1:0] thr  [ND];
   lvl_t          lvl     [ND];

   logic           wr_ctrl, wr_ien, wr_clr;
   logic [EV_W-1:0] ev;
   logic           pending, rx_avail;
   logic [19:0]    fst;
   logic           unused_hi;

   assign unused_hi = ^reg_wdata[31:19];

   assign wr_ctrl = reg_wr && (reg_addr == RA_CTRL);
   assign wr_ien  = reg_wr && (reg_addr == RA_IEN);
   assign wr_clr  = reg_wr && (reg_addr == RA_CLR);

   // direction 0 = transmit, direction 1 = receive
   assign fen[0]      = ctrl_q[CT_TXFEN];
   assign fen[1]      = ctrl_q[CT_RXFEN];
   assign thr[0]      = ctrl_q[CT_TXTHR_LSB +: THR_W];
   assign thr[1]      = ctrl_q[CT_RXTHR_LSB +: THR_W];
   assign push_req[0] = reg_wr && (reg_addr == RA_TXD);
   assign pdat[0]     = reg_wdata[SW-1:0];
   assign pop_req[0]  = tx_pop;
   assign push_req[1] = rx_push;
   assign pdat[1]     = rx_sample;
   assign pop_req[1]  = reg_rd && (reg_addr == RA_RXD);

   for (genvar d = 0; d < ND; d++) begin : g_dir
      sfh_fifo #(.DW(SW), .DEPTH(DEPTH)) u_fifo (
         .clk     (clk),
         .rst_n   (rst_n),
         .flush   (~fen[d]),
         .push    (push_req[d] & fen[d]),
         .wdat    (pdat[d]),
         .pop     (pop_req[d] & fen[d]),
         .head    (head[d]),
         .cnt     (cnt_raw[d]),
         .push_ok (push_ok[d]),
         .pop_ok  (pop_ok[d]),
         .ovf_ev  (ovf_ev[d]),
         .stv_ev  (stv_ev[d])
      );
      sfh_level #(.DEPTH(DEPTH), .CW(CW), .TW(THR_W)) u_lvl (
         .cnt     (cnt_raw[d]),
         .thr     (thr[d]),
         .en      (fen[d]),
         .lvl     (lvl[d]),
         .cnt_vis (cnt_vis[d])
      );
   end

   always_comb begin
      ctrl_nxt         = reg_wdata[18:0] & CT_MASK;
      ctrl_nxt[CT_PEN] = reg_wdata[CT_PEN] |
                         (ctrl_q[CT_PEN] & (reg_wdata[CT_TXFEN] | reg_wdata[CT_RXFEN]));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         ie_q   <= '0;
         ws_q   <= 1'b0;
         ts_q   <= 1'b0;
         to_q   <= 1'b0;
         rs_q   <= 1'b0;
         ro_q   <= 1'b0;
      end else begin
         if (wr_ctrl) ctrl_q <= ctrl_nxt;
         if (wr_ien)  ie_q   <= reg_wdata[14:0] & IE_MASK;
         ws_q <= (ws_q & ~(wr_clr & reg_wdata[EV_WXFER])) | pop_ok[0] | push_ok[1];
         ts_q <= (ts_q & ~(wr_clr & reg_wdata[EV_TSTV])) | stv_ev[0];
         to_q <= (to_q & ~(wr_clr & reg_wdata[EV_TOVF])) | ovf_ev[0];
         rs_q <= (rs_q & ~(wr_clr & reg_wdata[EV_RSTV])) | stv_ev[1];
         ro_q <= (ro_q & ~(wr_clr & reg_wdata[EV_ROVF])) | ovf_ev[1];
      end
   end

   assign ev      = {ws_q, lvl[0], ts_q, to_q, lvl[1], rs_q, ro_q};
   assign pending = |(ev & ie_q[EV_W-1:0]);
   assign irq     = ie_q[IE_GLOBAL] & pending;
   assign fst     = {CNT_FIELD_W'(cnt_vis[0]), lvl[0], CNT_FIELD_W'(cnt_vis[1]), lvl[1]};
   assign port_en = ctrl_q[CT_PEN];

   assign tx_valid  = ~lvl[0].empty;
   assign tx_sample = head[0];
   assign rx_avail  = ~lvl[1].empty;

   assign dma_tx_req = ctrl_q[CT_TXDMA] & fen[0] & ~lvl[0].full & lvl[0].aempty;
   assign dma_rx_req = ctrl_q[CT_RXDMA] & fen[1] & ~lvl[1].empty & lvl[1].afull;

   always_comb begin
      reg_rdata = '0;
      if (reg_rd) begin
         unique case (reg_addr)
            RA_CTRL: reg_rdata[18:0] = ctrl_q;
            RA_RXD: begin
               reg_rdata[16]     = rx_avail;
               reg_rdata[SW-1:0] = rx_avail ? head[1] : '0;
            end
            RA_IEN:  reg_rdata[14:0] = ie_q;
            RA_IST:  reg_rdata[13:0] = {pending, ev};
            RA_FST:  reg_rdata[19:0] = fst;
            default: reg_rdata = '0;
         endcase
      end
   end
endmodule

// File: rtl/sfh_chk.sv
module sfh_chk
   import sfh_pkg::*;
#(
   parameter int DEPTH = 32,
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input logic          clk,
   input logic          rst_n,
   input logic          reg_wr,
   input logic [2:0]    reg_addr,
   input logic [31:0]   reg_wdata,
   input logic          irq,
   input logic          gie,
   input logic          ws,
   input logic          ts,
   input logic          ro,
   input logic          dma_tx_req,
   input lvl_t          tx_lvl,
   input logic [CW-1:0] tx_cnt,
   input logic          port_en
);
   logic clr_wr, ctrl_off_all;
   assign clr_wr       = reg_wr && (reg_addr == RA_CLR);
   assign ctrl_off_all = reg_wr && (reg_addr == RA_CTRL) && (reg_wdata[2:0] == 3'b000);

   a_r10_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
      !gie |-> !irq);

   a_r8_tx_starve_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (ts && !(clr_wr && reg_wdata[EV_TSTV])) |=> ts);

   a_r7_rx_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (ro && !(clr_wr && reg_wdata[EV_ROVF])) |=> ro);

   a_r9_wxfer_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (ws && !(clr_wr && reg_wdata[EV_WXFER])) |=> ws);

   a_r11_txdma_has_room: assert property (@(posedge clk) disable iff (!rst_n)
      dma_tx_req |-> !tx_lvl.full);

   a_r3_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
      tx_cnt <= CW'(DEPTH));

   a_r13_port_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (port_en && !ctrl_off_all) |=> port_en);
endmodule

bind snd_fifo_hub sfh_chk #(.DEPTH(DEPTH)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .reg_wr     (reg_wr),
   .reg_addr   (reg_addr),
   .reg_wdata  (reg_wdata),
   .irq        (irq),
   .gie        (ie_q[14]),
   .ws         (ws_q),
   .ts         (ts_q),
   .ro         (ro_q),
   .dma_tx_req (dma_tx_req),
   .tx_lvl     (lvl[0]),
   .tx_cnt     (cnt_raw[0]),
   .port_en    (port_en)
);

// File: tb/sim_snd_fifo_hub.sv
module sim_snd_fifo_hub;
   localparam int DEPTH = 32;
   localparam logic [31:0] CTRL_NORM = 32'h0000_9067;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0, reg_rd = 1'b0;
   logic [2:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        tx_pop = 1'b0, tx_valid;
   logic [15:0] tx_sample;
   logic        rx_push = 1'b0;
   logic [15:0] rx_sample = '0;
   logic        dma_tx_req, dma_rx_req, port_en, irq;

   always #5 clk = ~clk;

   snd_fifo_hub #(.SW(16), .DEPTH(DEPTH)) u0 (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .tx_pop(tx_pop), .tx_valid(tx_valid), .tx_sample(tx_sample),
      .rx_push(rx_push), .rx_sample(rx_sample),
      .dma_tx_req(dma_tx_req), .dma_rx_req(dma_rx_req),
      .port_en(port_en), .irq(irq)
   );

   int    checks = 0, fails = 0;
   bit    done = 0;
   string ctx = "";

   logic [18:0] m_ctrl = '0;
   logic [14:0] m_ie = '0;
   bit          m_ws, m_ts, m_to, m_rs, m_ro;
   logic [15:0] tq[$];
   logic [15:0] rq[$];

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s (%s) actual=%h expected=%h", tag, ctx, act, exp);
      end
   endtask

   task automatic finish_up();
      if (!done) begin
         done = 1;
         $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   endtask

   function automatic logic [3:0] flg(int cnt, int thr, bit en);
      int c = en ? cnt : 0;
      return {c == 0, c <= thr, c == DEPTH, (c + thr) >= DEPTH};
   endfunction

   function automatic int tcnt();
      return m_ctrl[2] ? tq.size() : 0;
   endfunction
   function automatic int rcnt();
      return m_ctrl[1] ? rq.size() : 0;
   endfunction
   function automatic logic [3:0] tflg();
      return flg(tq.size(), int'(m_ctrl[18:13]), m_ctrl[2]);
   endfunction
   function automatic logic [3:0] rflg();
      return flg(rq.size(), int'(m_ctrl[12:7]), m_ctrl[1]);
   endfunction
   function automatic logic [12:0] exp_ev();
      return {m_ws, tflg(), m_ts, m_to, rflg(), m_rs, m_ro};
   endfunction
   function automatic bit exp_pend();
      return |(exp_ev() & m_ie[12:0]);
   endfunction
   function automatic logic [31:0] exp_read(logic [2:0] a);
      logic [31:0] v = '0;
      case (a)
         3'd0: v[18:0] = m_ctrl;
         3'd2: if (rcnt() > 0) v = {15'b0, 1'b1, rq[0]};
         3'd3: v[14:0] = m_ie;
         3'd4: v[13:0] = {exp_pend(), exp_ev()};
         3'd5: v[19:0] = {6'(tcnt()), tflg(), 6'(rcnt()), rflg()};
         default: v = '0;
      endcase
      return v;
   endfunction
   function automatic string rtag(logic [2:0] a);
      case (a)
         3'd2: return "R4 rx data word";
         3'd4: return "R10 event status";
         3'd5: return "R5 fifo status";
         default: return "R2 register read";
      endcase
   endfunction

   task automatic cyc(bit wr, bit rd, logic [2:0] a, logic [31:0] wd,
                      bit txp, bit rxp, logic [15:0] rxd);
      bit tfen, rfen, cw, cr, cl, pen;
      reg_wr = wr; reg_rd = rd; reg_addr = a; reg_wdata = wd;
      tx_pop = txp; rx_push = rxp; rx_sample = rxd;
      #1;
      chk("R3 tx_valid", {31'b0, tx_valid}, {31'b0, tcnt() > 0});
      if (tcnt() > 0) chk("R3 tx_sample order", {16'b0, tx_sample}, {16'b0, tq[0]});
      chk("R10 irq", {31'b0, irq}, {31'b0, m_ie[14] & exp_pend()});
      chk("R11 dma_tx_req", {31'b0, dma_tx_req},
          {31'b0, m_ctrl[6] & m_ctrl[2] & (tq.size() < DEPTH) & (tq.size() <= int'(m_ctrl[18:13]))});
      chk("R11 dma_rx_req", {31'b0, dma_rx_req},
          {31'b0, m_ctrl[5] & m_ctrl[1] & (rq.size() > 0) & ((rq.size() + int'(m_ctrl[12:7])) >= DEPTH)});
      chk("R13 port_en", {31'b0, port_en}, {31'b0, m_ctrl[0]});
      if (rd) chk(rtag(a), reg_rdata, exp_read(a));
      // model step for the coming edge
      tfen = m_ctrl[2]; rfen = m_ctrl[1];
      cw = wr && a == 3'd1; cr = rd && a == 3'd2; cl = wr && a == 3'd6;
      if (cl) begin
         if (wd[12]) m_ws = 0;
         if (wd[7])  m_ts = 0;
         if (wd[6])  m_to = 0;
         if (wd[1])  m_rs = 0;
         if (wd[0])  m_ro = 0;
      end
      if (tfen) begin
         int n = tq.size();
         if (txp && n == 0) m_ts = 1;
         if (cw && n == DEPTH) m_to = 1;
         if (txp && n > 0) begin void'(tq.pop_front()); m_ws = 1; end
         if (cw && n < DEPTH) tq.push_back(wd[15:0]);
      end
      if (rfen) begin
         int n = rq.size();
         if (cr && n == 0) m_rs = 1;
         if (rxp && n == DEPTH) m_ro = 1;
         if (cr && n > 0) void'(rq.pop_front());
         if (rxp && n < DEPTH) begin rq.push_back(rxd); m_ws = 1; end
      end
      if (wr && a == 3'd0) begin
         pen = wd[0] | (m_ctrl[0] & (wd[2] | wd[1]));
         m_ctrl = wd[18:0] & 19'h7FFE7;
         m_ctrl[0] = pen;
         if (!m_ctrl[2]) tq.delete();
         if (!m_ctrl[1]) rq.delete();
      end
      if (wr && a == 3'd3) m_ie = wd[14:0] & 15'h5FFF;
      @(negedge clk);
   endtask

   task automatic idle();
      cyc(0, 0, 3'd0, 32'd0, 0, 0, 16'd0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
      finish_up();
   end

   initial begin
      void'($urandom(32'h5A17_0C3D));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      ctx = "R1 reset state";
      reg_rd = 1'b1; reg_addr = 3'd5; #1;
      chk("R1 fifo status after reset", reg_rdata, 32'h0000_300C);
      chk("R1 irq after reset", {31'b0, irq}, 32'd0);
      reg_rd = 1'b0;
      cyc(0, 1, 3'd4, 0, 0, 0, 0);
      cyc(0, 1, 3'd0, 0, 0, 0, 0);

      ctx = "R2 control and enable readback";
      cyc(1, 0, 3'd0, CTRL_NORM | 32'h18, 0, 0, 0);
      cyc(0, 1, 3'd0, 0, 0, 0, 0);
      cyc(1, 0, 3'd3, 32'h0000_7FFF, 0, 0, 0);
      cyc(0, 1, 3'd3, 0, 0, 0, 0);
      cyc(0, 1, 3'd7, 0, 0, 0, 0);
      cyc(1, 0, 3'd3, 32'h0000_40C3, 0, 0, 0);

      ctx = "R6 R7 fill transmit queue past depth";
      for (int i = 0; i < DEPTH + 1; i++) begin
         cyc(1, 0, 3'd1, 32'h0000_A000 + i, 0, 0, 0);
         if (i % 4 == 3) cyc(0, 1, 3'd5, 0, 0, 0, 0);
      end
      cyc(0, 1, 3'd4, 0, 0, 0, 0);

      ctx = "R9 clear transmit overflow";
      cyc(1, 0, 3'd6, 32'h40, 0, 0, 0);
      cyc(0, 1, 3'd4, 0, 0, 0, 0);

      ctx = "R3 drain transmit queue";
      for (int i = 0; i < DEPTH; i++) begin
         cyc(0, (i % 3 == 0), 3'd5, 0, 1, 0, 0);
      end
      ctx = "R8 R9 starve with same-cycle clear";
      cyc(1, 0, 3'd6, 32'h80, 1, 0, 0);
      cyc(0, 1, 3'd4, 0, 0, 0, 0);
      cyc(1, 0, 3'd6, 32'h1080, 0, 0, 0);
      cyc(0, 1, 3'd4, 0, 0, 0, 0);

      ctx = "R4 R6 receive fill and drain";
      for (int i = 0; i < DEPTH + 1; i++) begin
         cyc(0, (i % 5 == 0), 3'd5, 0, 0, 1, 16'h5000 + 16'(i));
      end
      cyc(0, 1, 3'd4, 0, 0, 0, 0);
      for (int i = 0; i < DEPTH + 1; i++) cyc(0, 1, 3'd2, 0, 0, 0, 0);
      cyc(0, 1, 3'd4, 0, 0, 0, 0);
      cyc(1, 0, 3'd6, 32'h1FFF, 0, 0, 0);

      ctx = "R14 same-cycle push and pop";
      cyc(1, 0, 3'd1, 32'h0000_BEEF, 1, 0, 0);
      cyc(0, 1, 3'd4, 0, 0, 0, 0);
      cyc(1, 0, 3'd1, 32'h0000_CAFE, 1, 0, 0);
      cyc(0, 1, 3'd5, 0, 0, 0, 0);
      for (int i = 0; i < DEPTH; i++) cyc(0, 0, 3'd0, 0, 0, 1, 16'h7700 + 16'(i));
      cyc(0, 1, 3'd2, 0, 0, 1, 16'h1234);
      cyc(0, 1, 3'd4, 0, 0, 0, 0);
      cyc(0, 1, 3'd5, 0, 0, 0, 0);

      ctx = "R12 disabled transmit queue";
      cyc(1, 0, 3'd0, CTRL_NORM & ~32'h4, 0, 0, 0);
      cyc(0, 1, 3'd5, 0, 0, 0, 0);
      cyc(1, 0, 3'd1, 32'h0000_1111, 0, 0, 0);
      cyc(0, 0, 3'd0, 0, 1, 0, 0);
      cyc(0, 1, 3'd4, 0, 0, 0, 0);
      cyc(1, 0, 3'd0, CTRL_NORM, 0, 0, 0);
      cyc(0, 1, 3'd5, 0, 0, 0, 0);

      ctx = "R13 port enable rule";
      cyc(1, 0, 3'd0, CTRL_NORM & ~32'h1, 0, 0, 0);
      idle();
      cyc(1, 0, 3'd0, 32'h0, 0, 0, 0);
      idle();
      cyc(1, 0, 3'd0, CTRL_NORM, 0, 0, 0);

      ctx = "random traffic R3 R4 R5 R7 R8 R9 R10 R11 R14";
      for (int ph = 0; ph < 4; ph++) begin
         int wbias = (ph % 2 == 0) ? 45 : 15;
         for (int k = 0; k < 1000; k++) begin
            int r = $urandom_range(0, 99);
            bit txp = ($urandom_range(0, 99) < ((ph % 2 == 0) ? 20 : 50));
            bit rxp = ($urandom_range(0, 99) < ((ph % 2 == 0) ? 50 : 20));
            logic [15:0] rd16 = 16'($urandom);
            if (r < wbias)
               cyc(1, 0, 3'd1, {16'b0, 16'($urandom)}, txp, rxp, rd16);
            else if (r < wbias + 25)
               cyc(0, 1, 3'd2, 0, txp, rxp, rd16);
            else if (r < wbias + 31)
               cyc(0, 1, 3'd5, 0, txp, rxp, rd16);
            else if (r < wbias + 37)
               cyc(0, 1, 3'd4, 0, txp, rxp, rd16);
            else if (r < wbias + 41)
               cyc(1, 0, 3'd6, {19'b0, 13'($urandom)}, txp, rxp, rd16);
            else if (r < wbias + 43)
               cyc(1, 0, 3'd0, {13'b0, 6'($urandom), 6'($urandom), 2'($urandom), 2'b0,
                               ($urandom_range(0, 7) != 0), ($urandom_range(0, 7) != 0),
                               1'($urandom)}, txp, rxp, rd16);
            else if (r < wbias + 44)
               cyc(1, 0, 3'd3, {17'b0, 15'($urandom)}, txp, rxp, rd16);
            else
               cyc(0, 0, 3'd0, 0, txp, rxp, rd16);
         end
      end
      idle();
      finish_up();
   end
endmodule